// File: doc/BRIEF.md
# Sub-vector reduction engine

This engine reduces short sub-vectors of 1 to 4 lanes that sit in an integer register array. The lanes of one sub-vector occupy consecutive registers. A command gives three register bases: two sources and one destination. It also gives the vector length, the sub-vector length, a mode bit, an operation select and a flag that asks for condition results. A one-cycle `start` pulse launches the command. The engine then walks the array through one read port and one write port, and pulses `done` when it has finished.

The mode bit selects one of two orders.

- **Vertical mode:** each lane is kept apart. Lane k of the destination accumulates lane k of every element of source B, starting from lane k of source A. Pointing source A at the destination gives an in-place accumulation.
- **Horizontal mode:** the lanes of each element of source A are folded together, from the first lane to the last. This gives one scalar per element, written to consecutive destination registers.

When condition results are requested, every written result also produces a 4-bit sign classification on a separate condition port. The condition port and the result write are active in the same cycle.

Top module: `subvec_reduce`

## Requirements
- R1: Element i, lane k of a vector with base register r lives in register (r + i*S + k) mod 2^RW. S is the sub-vector length, given on `sublen_m1` as S-1 (0 means 1 lane, 3 means 4 lanes).
- R2: With `horiz`=0, destination register dst+k for lane k in 0..S-1 receives a fold. The fold starts from lane k of the element at `src_a`, then applies op(acc, lane k of source B element i) for i = 0 up to VL-1, in that order.
- R3: With `horiz`=1, element i in 0..VL-1 produces one result, written to register dst+i. The fold starts from lane 0 of source A element i and folds in lanes 1..S-1 left to right.
- R4: `op` selects the fold: 000 add (modulo 2^64), 001 AND, 010 OR, 011 XOR, 100 signed minimum, 101 signed maximum.
- R5: A condition field is 4 bits, bit 3 down to bit 0. Bit 3 is set when the result is negative as a signed value. Bit 2 is set when the result is above zero. Bit 1 is set when the result equals zero. Bit 0 is always 0. `cr_idx` carries the result number: lane k in vertical mode, element i in horizontal mode.
- R6: `cr_we` pulses only when `cr_en` was set at start. It pulses exactly once per written result, in the same cycle as that result's `wr_en`, and never for intermediate steps.
- R7: With S=1, horizontal mode copies each source A element to dst+i. Vertical mode accumulates a single scalar into dst.
- R8: A command with VL=0 raises `done` in the cycle after `start` and performs no write and no condition output.
- R9: `done` is high for exactly one cycle, the cycle right after the last result write.
- R10: The engine issues at most one write per cycle. A command writes exactly S results in vertical mode or VL results in horizontal mode, and touches no other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a command when idle |
| horiz | input | 1 | 1 = fold lanes within each element, 0 = accumulate each lane across the vector |
| cr_en | input | 1 | Request a condition field per result |
| op | input | 3 | Fold operation select |
| sublen_m1 | input | 2 | Sub-vector length minus one |
| vl | input | VLW | Vector length in elements |
| src_a | input | RW | Base register of source A |
| src_b | input | RW | Base register of source B (vertical mode) |
| dst | input | RW | Base register of the destination |
| rd_en | output | 1 | Read strobe |
| rd_addr | output | RW | Read register number |
| rd_data | input | XLEN | Read data, combinational from `rd_addr` |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | RW | Write register number |
| wr_data | output | XLEN | Write data |
| cr_we | output | 1 | Condition field valid |
| cr_idx | output | VLW | Result number of the condition field |
| cr_val | output | 4 | Condition field |
| done | output | 1 | Command complete, one cycle |

## Verification
Two things meet in one cycle: the result write and its condition field. Each condition output must line up with the matching `wr_en` and describe that same value. The bench gathers both streams by cycle number. It compares index, value and timing against results computed from a snapshot of the array. It includes runs crafted so that results are zero, negative and positive.

A second collision is a write landing on a register that the same command has already read. This is provoked with in-place runs: destination equal to source A in both modes. The bench judges these runs by the final contents of the whole array.

// File: rtl/sr_pkg.sv
package sr_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_AND = 3'b001,
        OP_OR  = 3'b010,
        OP_XOR = 3'b011,
        OP_MIN = 3'b100,
        OP_MAX = 3'b101
    } sr_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_FOLD,
        ST_WRITE,
        ST_DONE
    } sr_state_e;

    // sign classification of one result, bit 3 down to bit 0
    typedef struct packed {
        logic neg;
        logic pos;
        logic zero;
        logic rsvd;
    } sr_cond_t;

    localparam int SR_CONDW = $bits(sr_cond_t);

endpackage

// File: rtl/sr_alu.sv
module sr_alu
    import sr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  sr_op_e            op,
    input  logic [XLEN-1:0]   acc,
    input  logic [XLEN-1:0]   nxt,
    output logic [XLEN-1:0]   res
);
    always_comb begin
        case (op)
            OP_AND:  res = acc & nxt;
            OP_OR:   res = acc | nxt;
            OP_XOR:  res = acc ^ nxt;
            OP_MIN:  res = ($signed(acc) < $signed(nxt)) ? acc : nxt;
            OP_MAX:  res = ($signed(acc) > $signed(nxt)) ? acc : nxt;
            default: res = acc + nxt;
        endcase
    end
endmodule

// File: rtl/sr_cond.sv
module sr_cond
    import sr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]      val,
    output logic [SR_CONDW-1:0]  cond
);
    sr_cond_t c;

    always_comb begin
        c.neg  = val[XLEN-1];
        c.zero = (val == '0);
        c.pos  = !c.neg && !c.zero;
        c.rsvd = 1'b0;
        cond   = c;
    end
endmodule

// File: rtl/sr_addr.sv
module sr_addr #(
    parameter int RW  = 5,
    parameter int VLW = 5
) (
    input  logic            horiz,
    input  logic            first,
    input  logic [2:0]      slen,
    input  logic [VLW-1:0]  outer,
    input  logic [VLW-1:0]  inner,
    input  logic [RW-1:0]   base_a,
    input  logic [RW-1:0]   base_b,
    input  logic [RW-1:0]   base_d,
    output logic [RW-1:0]   rd_addr,
    output logic [RW-1:0]   wr_addr
);
    localparam int AW = (VLW + 3 > RW) ? VLW + 3 : RW;

    logic [AW-1:0] ow, iw, sw, aw, bw, dw, elem_a, rd_full, wr_full;

    always_comb begin
        ow     = AW'(outer);
        iw     = AW'(inner);
        sw     = AW'(slen);
        aw     = AW'(base_a);
        bw     = AW'(base_b);
        dw     = AW'(base_d);
        elem_a = aw + ow * sw;
        if (first)
            rd_full = horiz ? elem_a : aw + ow;
        else
            rd_full = horiz ? elem_a + iw : bw + iw * sw + ow;
        wr_full = dw + ow;
        rd_addr = RW'(rd_full);
        wr_addr = RW'(wr_full);
    end
endmodule

// File: rtl/subvec_reduce.sv
module subvec_reduce
    import sr_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int RW   = 5,
    parameter int VLW  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             horiz,
    input  logic             cr_en,
    input  logic [2:0]       op,
    input  logic [1:0]       sublen_m1,
    input  logic [VLW-1:0]   vl,
    input  logic [RW-1:0]    src_a,
    input  logic [RW-1:0]    src_b,
    input  logic [RW-1:0]    dst,
    output logic             rd_en,
    output logic [RW-1:0]    rd_addr,
    input  logic [XLEN-1:0]  rd_data,
    output logic             wr_en,
    output logic [RW-1:0]    wr_addr,
    output logic [XLEN-1:0]  wr_data,
    output logic             cr_we,
    output logic [VLW-1:0]   cr_idx,
    output logic [3:0]       cr_val,
    output logic             done
);
    typedef struct packed {
        logic            horiz;
        logic            cr_en;
        sr_op_e          op;
        logic [2:0]      slen;
        logic [VLW-1:0]  vl;
        logic [RW-1:0]   a;
        logic [RW-1:0]   b;
        logic [RW-1:0]   d;
    } cmd_t;

    sr_state_e        state;
    cmd_t             cmd;
    logic [VLW-1:0]   outer, inner;
    logic [XLEN-1:0]  acc, fold_res;
    logic [VLW-1:0]   slen_v, outer_last, inner_last;
    logic             no_fold;

    always_comb begin
        slen_v     = VLW'(cmd.slen);
        outer_last = cmd.horiz ? cmd.vl - VLW'(1) : slen_v - VLW'(1);
        inner_last = cmd.horiz ? slen_v - VLW'(1) : cmd.vl - VLW'(1);
        no_fold    = cmd.horiz && (cmd.slen == 3'd1);
    end

    sr_alu #(.XLEN(XLEN)) u_alu (
        .op  (cmd.op),
        .acc (acc),
        .nxt (rd_data),
        .res (fold_res)
    );

    sr_addr #(.RW(RW), .VLW(VLW)) u_addr (
        .horiz   (cmd.horiz),
        .first   (state == ST_FIRST),
        .slen    (cmd.slen),
        .outer   (outer),
        .inner   (inner),
        .base_a  (cmd.a),
        .base_b  (cmd.b),
        .base_d  (cmd.d),
        .rd_addr (rd_addr),
        .wr_addr (wr_addr)
    );

    sr_cond #(.XLEN(XLEN)) u_cond (
        .val  (acc),
        .cond (cr_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cmd   <= '0;
            outer <= '0;
            inner <= '0;
            acc   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    cmd.horiz <= horiz;
                    cmd.cr_en <= cr_en;
                    cmd.op    <= sr_op_e'(op);
                    cmd.slen  <= {1'b0, sublen_m1} + 3'd1;
                    cmd.vl    <= vl;
                    cmd.a     <= src_a;
                    cmd.b     <= src_b;
                    cmd.d     <= dst;
                    outer     <= '0;
                    state     <= (vl == '0) ? ST_DONE : ST_FIRST;
                end
                ST_FIRST: begin
                    acc   <= rd_data;
                    inner <= cmd.horiz ? VLW'(1) : '0;
                    state <= no_fold ? ST_WRITE : ST_FOLD;
                end
                ST_FOLD: begin
                    acc <= fold_res;
                    if (inner == inner_last) state <= ST_WRITE;
                    else                     inner <= inner + VLW'(1);
                end
                ST_WRITE: begin
                    if (outer == outer_last) state <= ST_DONE;
                    else begin
                        outer <= outer + VLW'(1);
                        state <= ST_FIRST;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_en   = (state == ST_FIRST) || (state == ST_FOLD);
        wr_en   = (state == ST_WRITE);
        wr_data = acc;
        cr_we   = wr_en && cmd.cr_en;
        cr_idx  = outer;
        done    = (state == ST_DONE);
    end

    // R9: the final write of a command is followed directly by done
    p_done_after_last_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && outer == outer_last) |=> done);

    // R9: done never lasts two cycles
    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: an empty command completes at once with no write
    p_empty_cmd_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start && vl == '0) |=> (done && !wr_en && !cr_we));

    // R10: writes never occur back to back, and never while reading
    p_write_spacing_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);
    p_write_no_read_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !rd_en);

    // R5: exactly one sign class is reported and the low bit stays clear
    p_cond_class_r5: assert property (@(posedge clk) disable iff (rst)
        cr_we |-> ($countones(cr_val[3:1]) == 1 && !cr_val[0]));

    // R6: condition output only accompanies a result write
    p_cond_with_write_r6: assert property (@(posedge clk) disable iff (rst)
        cr_we |-> (wr_en && !done));

endmodule

// File: tb/tb_subvec_reduce.sv
`timescale 1ns/1ps
module tb_subvec_reduce;

    localparam int XLEN = 64;
    localparam int RW   = 5;
    localparam int VLW  = 5;
    localparam int NREG = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic            horiz = 1'b0;
    logic            cr_en = 1'b0;
    logic [2:0]      op = 3'd0;
    logic [1:0]      sublen_m1 = 2'd0;
    logic [VLW-1:0]  vl = '0;
    logic [RW-1:0]   src_a = '0, src_b = '0, dst = '0;
    logic            rd_en, wr_en, cr_we, done;
    logic [RW-1:0]   rd_addr, wr_addr;
    logic [XLEN-1:0] rd_data, wr_data;
    logic [VLW-1:0]  cr_idx;
    logic [3:0]      cr_val;

    always #2 clk = ~clk;

    subvec_reduce #(.XLEN(XLEN), .RW(RW), .VLW(VLW)) dut (
        .clk(clk), .rst(rst), .start(start), .horiz(horiz), .cr_en(cr_en),
        .op(op), .sublen_m1(sublen_m1), .vl(vl), .src_a(src_a), .src_b(src_b),
        .dst(dst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cr_we(cr_we),
        .cr_idx(cr_idx), .cr_val(cr_val), .done(done)
    );

    // register array with a bench load port
    logic [XLEN-1:0] rf [NREG];
    logic            tb_we = 1'b0;
    logic [RW-1:0]   tb_wa = '0;
    logic [XLEN-1:0] tb_wd = '0;

    assign rd_data = rf[rd_addr];
    always @(posedge clk) begin
        if (tb_we)      rf[tb_wa]   <= tb_wd;
        else if (wr_en) rf[wr_addr] <= wr_data;
    end

    // monitor, sampling mid-cycle
    int              cyc = 0, nw = 0, ncr = 0, norphan = 0, ndone = 0;
    int              done_cyc = 0, st_cyc = 0;
    logic            mon_clr = 1'b0;
    logic [RW-1:0]   wa_log [64];
    logic [XLEN-1:0] wd_log [64];
    int              wc_log [64];
    logic [3:0]      cv_log [64];
    logic [VLW-1:0]  ci_log [64];

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (mon_clr) begin
            nw <= 0; ncr <= 0; norphan <= 0; ndone <= 0;
        end else if (!rst) begin
            if (wr_en && nw < 64) begin
                wa_log[nw] <= wr_addr; wd_log[nw] <= wr_data; wc_log[nw] <= cyc;
                nw <= nw + 1;
            end
            if (cr_we && ncr < 64) begin
                cv_log[ncr] <= cr_val; ci_log[ncr] <= cr_idx;
                ncr <= ncr + 1;
            end
            if (cr_we && !wr_en) norphan <= norphan + 1;
            if (done) begin ndone <= ndone + 1; done_cyc <= cyc; end
            if (start) st_cyc <= cyc;
        end
    end

    int nchk = 0, nfail = 0;

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_op(input logic [2:0] f, input logic [63:0] x,
                                           input logic [63:0] y);
        case (f)
            3'b001:  return x & y;
            3'b010:  return x | y;
            3'b011:  return x ^ y;
            3'b100:  return ($signed(x) <= $signed(y)) ? x : y;
            3'b101:  return ($signed(x) >= $signed(y)) ? x : y;
            default: return x + y;
        endcase
    endfunction

    function automatic logic [3:0] ref_cond(input logic [63:0] v);
        return {$signed(v) < 0, $signed(v) > 0, v == 64'd0, 1'b0};
    endfunction

    task automatic load_pattern(input logic [63:0] seed);
        @(posedge clk); #1;
        tb_we = 1'b1;
        for (int i = 0; i < NREG; i++) begin
            tb_wa = RW'(i);
            tb_wd = (64'(i + 1) * 64'h9E37_79B9_7F4A_7C15) ^ seed;
            @(posedge clk); #1;
        end
        tb_we = 1'b0;
    endtask

    task automatic set_reg(input int a, input logic [63:0] v);
        @(posedge clk); #1;
        tb_we = 1'b1; tb_wa = RW'(a); tb_wd = v;
        @(posedge clk); #1;
        tb_we = 1'b0;
    endtask

    task automatic run_case(input string req, input logic [2:0] f, input logic hz,
                            input int s, input int n, input int a, input int b,
                            input int d, input logic ce);
        logic [63:0] snap [NREG];
        logic [63:0] ex [32];
        int          nres;
        logic [63:0] r;
        for (int i = 0; i < NREG; i++) snap[i] = rf[i];
        nres = (n == 0) ? 0 : (hz ? n : s);
        for (int o = 0; o < nres; o++) begin
            if (hz) begin
                r = snap[(a + o*s) % NREG];
                for (int k = 1; k < s; k++) r = ref_op(f, r, snap[(a + o*s + k) % NREG]);
            end else begin
                r = snap[(a + o) % NREG];
                for (int i = 0; i < n; i++) r = ref_op(f, r, snap[(b + i*s + o) % NREG]);
            end
            ex[o] = r;
        end
        for (int o = 0; o < nres; o++) snap[(d + o) % NREG] = ex[o];

        @(posedge clk); #1 mon_clr = 1'b1;
        @(posedge clk); #1 mon_clr = 1'b0;
        op = f; horiz = hz; sublen_m1 = 2'(s - 1); vl = VLW'(n);
        src_a = RW'(a); src_b = RW'(b); dst = RW'(d); cr_en = ce; start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        for (int t = 0; t < 400 && ndone == 0; t++) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;

        chk(nw == nres, "R10", "write count", 64'(nw), 64'(nres));
        for (int o = 0; o < nres && o < nw; o++)
            chk(wa_log[o] == RW'(d + o) && wd_log[o] == ex[o], req, "result",
                wd_log[o], ex[o]);
        if (ce) begin
            chk(ncr == nres && norphan == 0, "R6", "condition count", 64'(ncr), 64'(nres));
            for (int o = 0; o < nres && o < ncr; o++)
                chk(cv_log[o] == ref_cond(ex[o]) && ci_log[o] == VLW'(o), "R5",
                    "condition field", {ci_log[o], cv_log[o]},
                    {VLW'(o), ref_cond(ex[o])});
        end else begin
            chk(ncr == 0, "R6", "condition without request", 64'(ncr), 64'd0);
        end
        chk(ndone == 1, "R9", "done pulses", 64'(ndone), 64'd1);
        if (nres > 0)
            chk(done_cyc == wc_log[nres-1] + 1, "R9", "done cycle",
                64'(done_cyc), 64'(wc_log[nres-1] + 1));
        else
            chk(done_cyc == st_cyc + 1, "R8", "empty done cycle",
                64'(done_cyc), 64'(st_cyc + 1));
        for (int i = 0; i < NREG; i++)
            chk(rf[i] == snap[i], "R10", "array contents", rf[i], snap[i]);
    endtask

    task automatic t_reset;
        chk(done == 1'b0, "R9", "done in reset", 64'(done), 64'd0);
        chk(wr_en == 1'b0, "R10", "write in reset", 64'(wr_en), 64'd0);
        chk(cr_we == 1'b0, "R6", "condition in reset", 64'(cr_we), 64'd0);
    endtask

    task automatic t_vertical;
        load_pattern(64'h1111);
        run_case("R2", 3'b000, 1'b0, 2, 3, 0, 4, 20, 1'b1);   // R1 R2 R4 add
        load_pattern(64'h2222);
        run_case("R2", 3'b011, 1'b0, 3, 4, 0, 8, 0, 1'b0);    // in place, R4 xor
        load_pattern(64'h3333);
        run_case("R2", 3'b010, 1'b0, 4, 2, 24, 8, 28, 1'b1);  // R4 or
    endtask

    task automatic t_horizontal;
        load_pattern(64'h4444);
        run_case("R3", 3'b101, 1'b1, 4, 3, 0, 0, 16, 1'b1);   // R1 R3 R4 max
        load_pattern(64'h5555);
        run_case("R3", 3'b100, 1'b1, 3, 4, 4, 0, 4, 1'b1);    // in place, R4 min
        load_pattern(64'h6666);
        run_case("R3", 3'b001, 1'b1, 2, 5, 10, 0, 1, 1'b0);   // R4 and
    endtask

    task automatic t_single_lane;
        load_pattern(64'h7777);
        run_case("R7", 3'b000, 1'b1, 1, 6, 2, 0, 20, 1'b1);   // copy
        load_pattern(64'h8888);
        run_case("R7", 3'b000, 1'b0, 1, 5, 3, 10, 30, 1'b0);  // scalar sum
    endtask

    task automatic t_empty;
        load_pattern(64'h9999);
        run_case("R8", 3'b000, 1'b0, 4, 0, 0, 4, 8, 1'b1);
        run_case("R8", 3'b011, 1'b1, 2, 0, 0, 0, 8, 1'b1);
    endtask

    task automatic t_condition_classes;
        load_pattern(64'hAAAA);
        set_reg(0, 64'h0000_0000_0000_1234); set_reg(1, 64'h0000_0000_0000_1234);
        set_reg(2, 64'h8000_0000_0000_0000); set_reg(3, 64'h0000_0000_0000_0001);
        set_reg(4, 64'h0000_0000_0000_00F0); set_reg(5, 64'h0000_0000_0000_000F);
        run_case("R5", 3'b011, 1'b1, 2, 3, 0, 0, 12, 1'b1);   // zero, negative, positive
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) rf[i] = '0;
        rst = 1'b1;
        repeat (4) @(posedge clk);
        #1 t_reset();
        rst = 1'b0;
        t_vertical();
        t_horizontal();
        t_single_lane();
        t_empty();
        t_condition_classes();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule